// File: doc/BRIEF.md
# UART Receive Majority-Vote Bit Sampler

This block recovers the value of each received serial bit by reading the line three times near the middle of the bit and voting. It runs on the baud source clock, so one clock cycle is one baud-source period. A bit-start pulse from the surrounding receiver begins each bit. At that pulse the block captures the divisor N, which is the number of source periods per bit, and the current modulation bit m. It then counts source periods from the pulse and takes the three samples around the midpoint INT(N/2)+m.

The serial input is asynchronous and first passes through a two-flop synchroniser. When the third sample has been taken, the block registers the 2-of-3 majority value and raises a one-cycle valid strobe. Start-bit detection, framing and buffering are done elsewhere. Divisors below 4 are outside the supported range.

Top module: `rx_vote_sampler`

## Requirements
- R1: The serial input reaches the sampling logic through exactly two flip-flops. A sample taken at the clock edge k edges after the bit-start edge sees the line value that was present at edge k-2.
- R2: Let the bit-start edge be edge 0. The midpoint is M = INT(N/2) + m. Samples are taken at edges M-1, M and M+1 after edge 0.
- R3: The voted value is 1 when at least two of the three samples are 1, and 0 otherwise. A single deviating sample therefore has no effect on the result.
- R4: The valid strobe is high for exactly one cycle, the cycle after edge M+1. The voted value is updated in that same cycle and holds until the next strobe.
- R5: A bit-start pulse at any time restarts the count from zero and abandons any window in progress. No strobe is produced for the abandoned bit.
- R6: N and m are captured at the bit-start edge. Changes to either input later in the bit do not move the sample window.
- R7: Line values at edges outside M-1, M and M+1 have no effect on the voted value.
- R8: In reset, and after reset until the first strobe, the valid strobe is 0 and the voted value is 1 (idle line level).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Baud source clock; one cycle is one source period |
| rst | input | 1 | Synchronous active-high reset |
| rx_async | input | 1 | Asynchronous serial receive line |
| div_n | input | CNT_W | Source periods per bit (N), captured at bit start |
| mod_bit | input | 1 | Current modulation bit m, captured at bit start |
| bit_start | input | 1 | One-cycle pulse marking the start of a bit |
| bit_val | output | 1 | Majority-voted bit value |
| bit_vld | output | 1 | One-cycle strobe when bit_val is updated |

## Verification
The hardest case to reach from the ports is one where exactly one of the three samples in the window disagrees with the other two, while the line outside the window carries the opposite value. This case needs the line to be driven per clock with the two-stage synchroniser delay taken into account. For every bit, the bench builds a per-edge line profile from the captured N and m. It places the three chosen samples at edges M-1, M and M+1 and fills every other edge with a chosen outside value. It drives each entry two edges early. The random bits also scramble the divisor and modulation inputs after the start pulse. Directed bits cover the smallest divisor, odd divisors with m set, and a restart issued inside an open window.

// File: rtl/rx_vote_pkg.sv
package rx_vote_pkg;
  localparam int SAMPLES = 3;

  typedef struct packed {
    logic take_first;
    logic take_mid;
    logic take_last;
  } take_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2,
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{IDLE}};
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_chk
      // R1: each stage follows the previous one a cycle later
      a_r1_stage_follow: assert property (@(posedge clk) disable iff (rst)
        chain_q[g] == $past(chain_q[g-1]));
    end
  endgenerate
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
  import rx_vote_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_start,
  input  logic [CNT_W-1:0] div_n,
  input  logic             mod_bit,
  output take_t            take
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mid_q;
  logic             active_q;
  logic [CNT_W-1:0] mid_lo, mid_hi;

  assign mid_lo = mid_q - CNT_W'(1);
  assign mid_hi = mid_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      mid_q    <= '0;
      active_q <= 1'b0;
    end else if (bit_start) begin
      cnt_q    <= CNT_W'(1);
      mid_q    <= (div_n >> 1) + CNT_W'(mod_bit);
      active_q <= 1'b1;
    end else if (active_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == mid_hi) active_q <= 1'b0;
    end
  end

  always_comb begin
    take.take_first = active_q && !bit_start && (cnt_q == mid_lo);
    take.take_mid   = active_q && !bit_start && (cnt_q == mid_q);
    take.take_last  = active_q && !bit_start && (cnt_q == mid_hi);
  end

  // R5: a start pulse always reloads the count to one
  a_r5_restart: assert property (@(posedge clk) disable iff (rst)
    bit_start |=> (cnt_q == CNT_W'(1)) && active_q);
  // R6: midpoint is frozen while a bit is in progress
  a_r6_mid_frozen: assert property (@(posedge clk) disable iff (rst)
    (active_q && !bit_start) |=> $stable(mid_q));
  // R2: at most one sample point per edge
  a_r2_one_take: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take.take_first, take.take_mid, take.take_last}));
  // R2: the last sample closes the window
  a_r2_window_close: assert property (@(posedge clk) disable iff (rst)
    (take.take_last && !bit_start) |=> !active_q || $past(bit_start));
endmodule

// File: rtl/rx_vote_unit.sv
module rx_vote_unit
  import rx_vote_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  line,
  input  take_t take,
  output logic  bit_val,
  output logic  bit_vld
);
  logic smp_first_q, smp_mid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_first_q <= 1'b1;
      smp_mid_q   <= 1'b1;
      bit_val     <= 1'b1;
      bit_vld     <= 1'b0;
    end else begin
      if (take.take_first) smp_first_q <= line;
      if (take.take_mid)   smp_mid_q   <= line;
      bit_vld <= take.take_last;
      if (take.take_last) bit_val <= vote3(smp_first_q, smp_mid_q, line);
    end
  end

  // R4: strobe lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> !bit_vld);
  // R4: strobe only follows a last-sample edge
  a_r4_after_last: assert property (@(posedge clk) disable iff (rst)
    bit_vld |-> $past(take.take_last));
  // R4: value holds between strobes
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !take.take_last |=> $stable(bit_val));
endmodule

// File: rtl/rx_vote_sampler.sv
module rx_vote_sampler
  import rx_vote_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_async,
  input  logic [CNT_W-1:0] div_n,
  input  logic             mod_bit,
  input  logic             bit_start,
  output logic             bit_val,
  output logic             bit_vld
);
  logic  line_s;
  take_t take;

  rx_line_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_async),
    .dout (line_s)
  );

  rx_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .bit_start (bit_start),
    .div_n     (div_n),
    .mod_bit   (mod_bit),
    .take      (take)
  );

  rx_vote_unit u_vote (
    .clk     (clk),
    .rst     (rst),
    .line    (line_s),
    .take    (take),
    .bit_val (bit_val),
    .bit_vld (bit_vld)
  );

  // R8: outputs idle during reset (checked on the following edge)
  a_r8_reset_idle: assert property (@(posedge clk)
    rst |=> !bit_vld && bit_val);
endmodule

// File: tb/rx_vote_sampler_test.sv
module rx_vote_sampler_test;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rx_async = 1'b1;
  logic [CNT_W-1:0] div_n = 16'd8;
  logic             mod_bit = 1'b0;
  logic             bit_start = 1'b0;
  logic             bit_val, bit_vld;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_vote_sampler #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .rx_async(rx_async), .div_n(div_n),
    .mod_bit(mod_bit), .bit_start(bit_start), .bit_val(bit_val), .bit_vld(bit_vld)
  );

  function automatic logic maj(input logic a, input logic b, input logic c);
    return (a + b + c) >= 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // line value for edge k after bit start
  function automatic logic line_at(input int k, input int mid, input logic a,
                                   input logic b, input logic c, input logic outv);
    if (k == mid - 1) return a;
    if (k == mid)     return b;
    if (k == mid + 1) return c;
    return outv;
  endfunction

  // one full bit: R1 R2 R3 R4 R6 R7
  task automatic run_bit(input int n, input logic m, input logic a, input logic b,
                         input logic c, input logic outv, input bit scramble,
                         input string tag);
    int mid = n / 2 + m;
    logic expv = maj(a, b, c);
    @(negedge clk);
    div_n = CNT_W'(n); mod_bit = m; bit_start = 1'b1;
    rx_async = line_at(2, mid, a, b, c, outv);
    @(posedge clk);
    for (int j = 1; j <= mid + 1; j++) begin
      @(negedge clk);
      bit_start = 1'b0;
      rx_async = line_at(j + 2, mid, a, b, c, outv);
      if (scramble) begin
        div_n = CNT_W'($urandom_range(4, 60));
        mod_bit = ~mod_bit;
      end
      check(bit_vld == 1'b0, {tag, " R4 no early strobe"}, bit_vld, 0);
      @(posedge clk);
    end
    @(negedge clk);
    check(bit_vld == 1'b1, {tag, " R2 R4 strobe after last sample"}, bit_vld, 1);
    check(bit_val == expv, {tag, " R3 R7 voted value"}, bit_val, expv);
    @(negedge clk);
    check(bit_vld == 1'b0, {tag, " R4 strobe one cycle"}, bit_vld, 0);
    check(bit_val == expv, {tag, " R4 value held"}, bit_val, expv);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(bit_vld == 1'b0 && bit_val == 1'b1, "R8 reset state", {bit_vld, bit_val}, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(bit_vld == 1'b0 && bit_val == 1'b1, "R8 idle after reset", {bit_vld, bit_val}, 1);

    // directed corners
    run_bit(4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "smallest N R2");
    run_bit(4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "N4 m1 glitch R3");
    run_bit(7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "odd N glitch R3");
    run_bit(9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "scramble R6");
    run_bit(16, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "late glitch R7");

    // R5: restart inside an open window
    @(negedge clk);
    div_n = 16'd20; mod_bit = 1'b0; bit_start = 1'b1; rx_async = 1'b0;
    @(posedge clk);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      bit_start = 1'b0;
      check(bit_vld == 1'b0, "R5 aborted bit no strobe", bit_vld, 0);
    end
    run_bit(6, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R5 after restart");

    // random bits
    for (int i = 0; i < 60; i++) begin
      int n = $urandom_range(4, 40);
      logic m = 1'($urandom_range(0, 1));
      logic a = 1'($urandom_range(0, 1));
      logic b = 1'($urandom_range(0, 1));
      logic c = 1'($urandom_range(0, 1));
      logic o = 1'($urandom_range(0, 1));
      bit s = 1'($urandom_range(0, 1));
      run_bit(n, m, a, b, c, o, s, "random R1 R2 R3");
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule